// File: doc/BRIEF.md
# Four-Port Slot Interleaver with Port-0 Comma Marking

This block merges four per-port transmit streams, each one octet plus a control flag per word, into a single word stream that runs four times faster. A free-running slot counter picks the source port in a fixed rotation. Each port sees a ready strobe in the cycle its word is taken. The merged word leaves through a register one cycle later and goes to an 8B/10B encoder.

Only port 0 carries a marker. On that port every K28.5 control word is swapped for K28.1, so the far end can find which slot holds port 0. The swap works on the octet and control flag, not on encoded code-groups. The block also makes sure that only the first idle form goes out: a D16.2 data word that follows a K28.5 on the same port is turned into D5.6. In full-duplex mode, the error flag of a word whose enable is low is cleared before it leaves.

Top module: `quad_slot_interleaver`

## Requirements
- R1: While rst_n is low, out_data, out_ctl, out_en, out_er and out_slot are 0 and port_ready is 4'b0001. The first word after reset is released comes from port 0.
- R2: Ports are taken in the rotation 0, 1, 2, 3, 0, and so on. port_ready is one-hot with bit p set in the cycle port p's inputs are sampled. That word appears on the outputs one clock later, with out_slot equal to p.
- R3: A port-0 word with control flag 1 and octet 8'hBC (K28.5) leaves as control flag 1 and octet 8'h3C (K28.1).
- R4: Words from ports 1 to 3 that are not covered by R5 leave with the same octet and control flag. This includes K28.5. Port-0 words other than K28.5 also leave unchanged, including 8'hBC with control flag 0.
- R5: On any port, a data word (control flag 0) of 8'h50 (D16.2) leaves as 8'hC5 (D5.6) when the word taken just before it from the same port was K28.5. Otherwise 8'h50 passes unchanged.
- R6: When full_duplex is 1 and the word's enable is 0, out_er is 0. In every other case out_er equals the word's error input. out_en always equals the word's enable.
- R7: Inputs of a port outside its own slot have no effect on the outputs. This includes the history that R5 uses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | Full-duplex mode, enables error suppression |
| in_data | input | 32 | Octet of port p at bits [8p+7:8p] |
| in_ctl | input | 4 | Control flag per port |
| in_en | input | 4 | Transmit enable per port |
| in_er | input | 4 | Transmit error per port |
| port_ready | output | 4 | One-hot strobe: this port's word is taken now |
| out_data | output | 8 | Merged octet |
| out_ctl | output | 1 | Merged control flag |
| out_en | output | 1 | Merged enable |
| out_er | output | 1 | Merged error, suppressed per R6 |
| out_slot | output | 2 | Source port of the current output word |

## Verification
The hardest case to reach is the idle repair. It needs a K28.5 and then a D16.2 from the same port in two of that port's consecutive slots, while the other ports hold different words at those same cycles. The stimulus has a directed phase that gives each port K28.5, D16.2, D16.2 in successive slots of its own, and fills every cycle outside that port's slot with K28.5 and D16.2 decoys. Only the correct per-port history then yields the expected D5.6 followed by a plain D16.2. A reset in the middle of the run checks that the rotation restarts at port 0 and that the history is cleared.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
  localparam int OCT_W = 8;
  localparam logic [OCT_W-1:0] K28_5 = 8'hBC;
  localparam logic [OCT_W-1:0] K28_1 = 8'h3C;
  localparam logic [OCT_W-1:0] D16_2 = 8'h50;
  localparam logic [OCT_W-1:0] D5_6  = 8'hC5;

  typedef struct packed {
    logic             en;
    logic             er;
    logic             ctl;
    logic [OCT_W-1:0] data;
  } lane_t;
endpackage

// File: rtl/qsi_slot_ctr.sv
module qsi_slot_ctr #(
  parameter int NPORTS = 4,
  localparam int SEL_W = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SEL_W-1:0]  sel,
  output logic [NPORTS-1:0] ready
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NPORTS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    if (sel_q == LAST) sel_d = '0;
    else               sel_d = sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  for (genvar i = 0; i < NPORTS; i++) begin : g_rdy
    assign ready[i] = (sel_q == SEL_W'(i));
  end
endmodule

// File: rtl/qsi_port_sel.sv
module qsi_port_sel
  import qsi_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int SEL_W = $clog2(NPORTS)
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [NPORTS*OCT_W-1:0] in_data,
  input  logic [NPORTS-1:0]       in_ctl,
  input  logic [NPORTS-1:0]       in_en,
  input  logic [NPORTS-1:0]       in_er,
  output lane_t                   lane
);
  always_comb begin
    lane.data = in_data[int'(sel)*OCT_W +: OCT_W];
    lane.ctl  = in_ctl[sel];
    lane.en   = in_en[sel];
    lane.er   = in_er[sel];
  end
endmodule

// File: rtl/qsi_lane_fix.sv
module qsi_lane_fix
  import qsi_pkg::*;
(
  input  lane_t in_lane,
  input  logic  mark_slot,
  input  logic  prev_k,
  input  logic  full_duplex,
  output lane_t out_lane,
  output logic  is_k
);
  always_comb begin
    is_k     = in_lane.ctl && (in_lane.data == K28_5);
    out_lane = in_lane;
    if (mark_slot && is_k)
      out_lane.data = K28_1;
    else if (prev_k && !in_lane.ctl && (in_lane.data == D16_2))
      out_lane.data = D5_6;
    if (full_duplex && !in_lane.en)
      out_lane.er = 1'b0;
  end
endmodule

// File: rtl/quad_slot_interleaver.sv
module quad_slot_interleaver
  import qsi_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int SEL_W = $clog2(NPORTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    full_duplex,
  input  logic [NPORTS*OCT_W-1:0] in_data,
  input  logic [NPORTS-1:0]       in_ctl,
  input  logic [NPORTS-1:0]       in_en,
  input  logic [NPORTS-1:0]       in_er,
  output logic [NPORTS-1:0]       port_ready,
  output logic [OCT_W-1:0]        out_data,
  output logic                    out_ctl,
  output logic                    out_en,
  output logic                    out_er,
  output logic [SEL_W-1:0]        out_slot
);
  localparam logic [SEL_W-1:0] MARK_PORT = '0;

  logic [SEL_W-1:0]  sel;
  lane_t             raw_lane;
  lane_t             fix_lane;
  logic              is_k;
  logic [NPORTS-1:0] prevk_q;
  logic [NPORTS-1:0] prevk_d;
  lane_t             out_q;
  logic [SEL_W-1:0]  slot_q;

  qsi_slot_ctr #(.NPORTS(NPORTS)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .ready (port_ready)
  );

  qsi_port_sel #(.NPORTS(NPORTS)) u_sel (
    .sel     (sel),
    .in_data (in_data),
    .in_ctl  (in_ctl),
    .in_en   (in_en),
    .in_er   (in_er),
    .lane    (raw_lane)
  );

  qsi_lane_fix u_fix (
    .in_lane     (raw_lane),
    .mark_slot   (sel == MARK_PORT),
    .prev_k      (prevk_q[sel]),
    .full_duplex (full_duplex),
    .out_lane    (fix_lane),
    .is_k        (is_k)
  );

  always_comb begin
    prevk_d      = prevk_q;
    prevk_d[sel] = is_k;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevk_q <= '0;
      out_q   <= '0;
      slot_q  <= '0;
    end else begin
      prevk_q <= prevk_d;
      out_q   <= fix_lane;
      slot_q  <= sel;
    end
  end

  assign out_data = out_q.data;
  assign out_ctl  = out_q.ctl;
  assign out_en   = out_q.en;
  assign out_er   = out_q.er;
  assign out_slot = slot_q;
endmodule

// File: rtl/qsi_checker.sv
module qsi_checker #(
  parameter int NPORTS = 4,
  localparam int SEL_W = $clog2(NPORTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              full_duplex,
  input logic [NPORTS-1:0] port_ready,
  input logic [7:0]        out_data,
  input logic              out_ctl,
  input logic              out_en,
  input logic              out_er,
  input logic [SEL_W-1:0]  out_slot
);
  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_ready) == 1);

  p_ready_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> port_ready == {$past(port_ready[NPORTS-2:0]), $past(port_ready[NPORTS-1])});

  for (genvar i = 0; i < NPORTS; i++) begin : g_slot
    p_ready_to_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      port_ready[i] |=> out_slot == SEL_W'(i));
  end

  p_no_k285_port0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_slot == '0) && out_ctl |-> out_data != 8'hBC);

  p_er_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en && $past(full_duplex) |-> !out_er);
endmodule

bind quad_slot_interleaver qsi_checker #(.NPORTS(NPORTS)) u_chk (.*);

// File: tb/tb_quad_slot_interleaver.sv
module tb_quad_slot_interleaver;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         full_duplex;
  logic [N*8-1:0] in_data;
  logic [N-1:0] in_ctl, in_en, in_er;
  logic [N-1:0] port_ready;
  logic [7:0]   out_data;
  logic         out_ctl, out_en, out_er;
  logic [1:0]   out_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mprev [N];

  always #5 clk = ~clk;

  quad_slot_interleaver #(.NPORTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .in_data(in_data), .in_ctl(in_ctl), .in_en(in_en), .in_er(in_er),
    .port_ready(port_ready), .out_data(out_data), .out_ctl(out_ctl),
    .out_en(out_en), .out_er(out_er), .out_slot(out_slot)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // word = {en, er, ctl, data[7:0]}
  function automatic logic [10:0] gen(int c, int p);
    int k = c / 4;
    logic [7:0] d;
    logic ct, e, r;
    e = ((c >> 4) & 1) != 0;
    r = ((c >> 5) & 1) != 0;
    if (c < 2048) begin
      d  = 8'((k + p * 61) & 255);
      ct = c >= 1024;
    end else if ((c % 4) != p) begin
      // decoys outside the port's own slot (R7)
      d  = (c % 2 == 0) ? 8'hBC : 8'h50;
      ct = (c % 2 == 0);
    end else begin
      case (k % 4)
        0: begin d = 8'hBC; ct = 1'b1; end
        1: begin d = 8'h50; ct = 1'b0; end
        2: begin d = 8'h50; ct = 1'b0; end
        default: begin d = (p % 2 == 0) ? 8'hBC : 8'hC5; ct = (p % 2 == 0); end
      endcase
    end
    return {e, r, ct, d};
  endfunction

  function automatic logic fd_of(int c);
    return ((c >> 6) & 1) != 0;
  endfunction

  task automatic drive(int c);
    for (int p = 0; p < N; p++) begin
      logic [10:0] w = gen(c, p);
      in_data[p*8 +: 8] = w[7:0];
      in_ctl[p] = w[8];
      in_er[p]  = w[9];
      in_en[p]  = w[10];
    end
    full_duplex = fd_of(c);
  endtask

  task automatic check_reset_state();
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 out_ctl", int'(out_ctl), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 out_er", int'(out_er), 0);
    chk("R1 out_slot", int'(out_slot), 0);
    chk("R1 port_ready", int'(port_ready), 1);
  endtask

  task automatic run(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      int p = c % N;
      logic [10:0] w;
      logic [7:0] ed;
      logic eer;
      string rq;
      drive(c);
      #1;
      chk("R2 port_ready", int'(port_ready), 1 << p);
      w  = gen(c, p);
      ed = w[7:0];
      rq = "R4 data";
      if (p == 0 && w[8] && w[7:0] == 8'hBC) begin
        ed = 8'h3C; rq = "R3 data";
      end else if (!w[8] && w[7:0] == 8'h50) begin
        rq = "R5 data";
        if (mprev[p]) ed = 8'hC5;
      end
      if (c >= 2048) rq = {rq, " R7"};
      mprev[p] = w[8] && (w[7:0] == 8'hBC);
      eer = (fd_of(c) && !w[10]) ? 1'b0 : w[9];
      @(posedge clk);
      @(negedge clk);
      chk(rq, int'(out_data), int'(ed));
      chk("R4 ctl", int'(out_ctl), int'(w[8]));
      chk("R6 en", int'(out_en), int'(w[10]));
      chk("R6 er", int'(out_er), int'(eer));
      chk((c == 0) ? "R1 first slot" : "R2 out_slot", int'(out_slot), p);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0);
    for (int p = 0; p < N; p++) mprev[p] = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    run(2560);
    // reset in the middle of traffic
    rst_n = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    for (int p = 0; p < N; p++) mprev[p] = 1'b0;
    run(64);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule